// File: doc/BRIEF.md
# Framed Serial PCM Port

This block is the digital serial side of a single-channel voice codec. Both directions share one bit clock. Each direction has its own frame strobe and carries exactly one 8-bit sample per frame, most significant bit first. On the receive side, bits are taken from the serial input on falling bit-clock edges, starting at the receive strobe. Once all eight bits are in, the byte is handed to the decoder side in parallel with a one-cycle valid pulse. On the transmit side, a parallel sample is captured at the transmit strobe and shifted out on rising bit-clock edges. The output is modelled as a data bit plus an output enable. While the enable is low, the line counts as pulled high.

All serial inputs are sampled by a faster system clock `clk`, and their edges are found by comparing each input with its value one cycle earlier. Every state change happens at the `clk` edge where an input edge is first seen, and every output is registered, so the result shows on the ports one `clk` cycle later.

The port drops into a power-save state in three cases: power-down is requested, the bit clock stops toggling, or transmit strobes stop arriving. In that state the output is released and any receive frame in progress is discarded.

Top module: `pcm_serial_port`

## Requirements
- R1: A transmit slot is 8 bits, MSB first. `tx_dout` changes only at rising bit-clock edges (or at the launching strobe), and bit k of the slot is the sample's bit 7-k.
- R2: Receive bits are sampled on falling bit-clock edges. The first falling edge at or after the `rx_sync` rise carries the MSB, and `rx_byte` bit 7 holds the first bit received.
- R3: `rx_byte` changes only when the eighth bit of a frame has been shifted in. Each such update comes with exactly one cycle of `rx_valid` high, and the byte holds between updates.
- R4: If `tx_sync` rises while `bclk` is high (this includes the cycle of a `bclk` rise), the MSB is driven with `tx_oe` high from the next cycle. If it rises while `bclk` is low, `tx_oe` stays low until the next `bclk` rise, which launches the MSB.
- R5: Outside the 8 active bit slots, `tx_oe` is low. The rising edge after the eighth bit ends the slot, and `tx_dout` reads 1 whenever `tx_oe` is low.
- R6: `tx_sample` is captured at the transmit strobe. Changing it during the slot has no effect on the bits sent.
- R7: While `pd_n` is low, `tx_oe` is low from the next cycle and a receive frame in progress is abandoned without a `rx_valid` pulse.
- R8: If `bclk` shows no edge for `STALL_CLKS` consecutive `clk` cycles, the port enters power save: `tx_oe` goes low and the partial receive frame is discarded.
- R9: After `FRAME_BITS_MAX` rising `bclk` edges with no `tx_sync` rise, the port is in power save and ignores receive frames. The next `tx_sync` rise ends power save and starts its frame normally.
- R10: After reset, `rx_byte` is 0, `rx_valid` is 0, `tx_oe` is 0 and `tx_dout` is 1.
- R11: Transmit and receive framing are independent: a frame with only one strobe moves data in only that direction.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock that oversamples the serial pins |
| rst_n | input | 1 | Active-low synchronous reset |
| pd_n | input | 1 | Active-low power-down request |
| bclk | input | 1 | Serial bit clock shared by both directions |
| rx_sync | input | 1 | Receive frame strobe |
| rx_din | input | 1 | Serial receive data |
| tx_sync | input | 1 | Transmit frame strobe |
| tx_sample | input | 8 | Parallel sample to transmit |
| rx_byte | output | 8 | Last fully received sample |
| rx_valid | output | 1 | One-cycle pulse when rx_byte updates |
| tx_dout | output | 1 | Serial transmit data bit |
| tx_oe | output | 1 | Output enable for tx_dout; low means released |

## Verification
The hardest condition to reach from the ports is the strobe-starvation power save. It only appears after hundreds of bit clocks with no transmit strobe, so the stimulus runs a long idle stretch of bit clocks first. It then shows that a receive-only frame is ignored and that the next transmit strobe recovers the port. The strobe-to-bit-clock phase is the second delicate point. The strobe is placed in the same sampling cycle as a bit-clock rise, inside the high phase, and inside the low phase, and the enable and first bit are watched in each case.

// File: rtl/pcm_serial_port.sv
module pcm_serial_port #(
  parameter int SLOT_BITS      = 8,
  parameter int STALL_CLKS     = 64,
  parameter int FRAME_BITS_MAX = 320
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 pd_n,
  input  logic                 bclk,
  input  logic                 rx_sync,
  input  logic                 rx_din,
  input  logic                 tx_sync,
  input  logic [SLOT_BITS-1:0] tx_sample,
  output logic [SLOT_BITS-1:0] rx_byte,
  output logic                 rx_valid,
  output logic                 tx_dout,
  output logic                 tx_oe
);
  localparam int CW = $clog2(SLOT_BITS);
  localparam int SW = $clog2(STALL_CLKS + 1);
  localparam int FW = $clog2(FRAME_BITS_MAX + 1);
  localparam logic [CW-1:0] LAST = CW'(SLOT_BITS - 1);

  logic bclk_q, rxs_q, txs_q;
  logic b_rise, b_fall, rxs_rise, txs_rise;
  logic [SW-1:0] stall_cnt;
  logic [FW-1:0] frame_cnt;
  logic bclk_dead, sync_dead, saving;

  logic                 rx_act;
  logic [CW-1:0]        rx_cnt, rx_idx;
  logic [SLOT_BITS-1:0] rx_sh;

  logic                 tx_pend;
  logic [CW-1:0]        tx_cnt;
  logic [SLOT_BITS-1:0] tx_sh;

  assign b_rise   = bclk & ~bclk_q;
  assign b_fall   = ~bclk & bclk_q;
  assign rxs_rise = rx_sync & ~rxs_q;
  assign txs_rise = tx_sync & ~txs_q;

  assign bclk_dead = (stall_cnt == SW'(STALL_CLKS)) && !(b_rise || b_fall);
  assign sync_dead = (frame_cnt == FW'(FRAME_BITS_MAX)) && !txs_rise;
  assign saving    = !pd_n || bclk_dead || sync_dead;

  assign rx_idx  = rxs_rise ? '0 : rx_cnt;
  assign tx_dout = tx_oe ? tx_sh[SLOT_BITS-1] : 1'b1;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      bclk_q    <= 1'b0;
      rxs_q     <= 1'b0;
      txs_q     <= 1'b0;
      stall_cnt <= '0;
      frame_cnt <= '0;
    end else begin
      bclk_q <= bclk;
      rxs_q  <= rx_sync;
      txs_q  <= tx_sync;
      if (b_rise || b_fall)
        stall_cnt <= '0;
      else if (stall_cnt != SW'(STALL_CLKS))
        stall_cnt <= stall_cnt + 1'b1;
      if (txs_rise)
        frame_cnt <= '0;
      else if (b_rise && frame_cnt != FW'(FRAME_BITS_MAX))
        frame_cnt <= frame_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rx_act   <= 1'b0;
      rx_cnt   <= '0;
      rx_sh    <= '0;
      rx_byte  <= '0;
      rx_valid <= 1'b0;
    end else if (saving) begin
      rx_act   <= 1'b0;
      rx_valid <= 1'b0;
    end else begin
      rx_valid <= 1'b0;
      if (b_fall && (rx_act || rxs_rise)) begin
        rx_sh <= {rx_sh[SLOT_BITS-2:0], rx_din};
        if (rx_idx == LAST) begin
          rx_byte  <= {rx_sh[SLOT_BITS-2:0], rx_din};
          rx_valid <= 1'b1;
          rx_act   <= 1'b0;
        end else begin
          rx_cnt <= rx_idx + 1'b1;
          rx_act <= 1'b1;
        end
      end else if (rxs_rise) begin
        rx_act <= 1'b1;
        rx_cnt <= '0;
      end
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      tx_oe   <= 1'b0;
      tx_pend <= 1'b0;
      tx_cnt  <= '0;
      tx_sh   <= '0;
    end else if (saving) begin
      tx_oe   <= 1'b0;
      tx_pend <= 1'b0;
    end else if (txs_rise) begin
      tx_sh   <= tx_sample;
      tx_cnt  <= '0;
      tx_oe   <= bclk;
      tx_pend <= !bclk;
    end else if (b_rise) begin
      if (tx_pend) begin
        tx_oe   <= 1'b1;
        tx_pend <= 1'b0;
      end else if (tx_oe) begin
        if (tx_cnt == LAST) begin
          tx_oe <= 1'b0;
        end else begin
          tx_sh  <= {tx_sh[SLOT_BITS-2:0], 1'b0};
          tx_cnt <= tx_cnt + 1'b1;
        end
      end
    end
  end
endmodule

// File: rtl/pcm_serial_port_chk.sv
module pcm_serial_port_chk #(
  parameter int SLOT_BITS = 8
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 pd_n,
  input logic                 bclk,
  input logic                 tx_sync,
  input logic [SLOT_BITS-1:0] rx_byte,
  input logic                 rx_valid,
  input logic                 tx_dout,
  input logic                 tx_oe
);
  // R7
  pd_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !pd_n |=> !tx_oe);

  // R3
  valid_pulse_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_valid |=> !rx_valid);

  // R3
  byte_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rx_valid |-> $stable(rx_byte));

  // R4
  launch_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_oe) |-> $past(bclk));

  // R1
  bit_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_oe && $past(tx_oe) && !($past(bclk) && !$past(bclk, 2))
     && !($past(tx_sync) && !$past(tx_sync, 2))) |-> $stable(tx_dout));
endmodule

bind pcm_serial_port pcm_serial_port_chk #(.SLOT_BITS(SLOT_BITS)) chk_i (
  .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .bclk(bclk), .tx_sync(tx_sync),
  .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_dout(tx_dout), .tx_oe(tx_oe)
);

// File: tb/pcm_serial_port_tb.sv
`timescale 1ns/1ps
module pcm_serial_port_tb_top;
  logic clk = 1'b0, rst_n = 1'b0, pd_n = 1'b1, bclk = 1'b0;
  logic rx_sync = 1'b0, rx_din = 1'b0, tx_sync = 1'b0;
  logic [7:0] tx_sample = 8'h00;
  logic [7:0] rx_byte;
  logic rx_valid, tx_dout, tx_oe;

  int checks = 0, fails = 0, vcnt = 0;
  logic [7:0] vlast = 8'h00;

  always #2.5 clk = ~clk;

  pcm_serial_port dut_i (
    .clk(clk), .rst_n(rst_n), .pd_n(pd_n), .bclk(bclk), .rx_sync(rx_sync),
    .rx_din(rx_din), .tx_sync(tx_sync), .tx_sample(tx_sample),
    .rx_byte(rx_byte), .rx_valid(rx_valid), .tx_dout(tx_dout), .tx_oe(tx_oe)
  );

  always @(posedge clk)
    if (rst_n && rx_valid) begin
      vcnt  <= vcnt + 1;
      vlast <= rx_byte;
    end

  // {tx[7:0], rx[7:0], mode[1:0], do_tx, do_rx}
  localparam logic [19:0] VEC [0:5] = '{
    {8'hA5, 8'h3C, 2'd0, 1'b1, 1'b1},
    {8'h80, 8'h01, 2'd1, 1'b1, 1'b1},
    {8'h01, 8'h80, 2'd2, 1'b1, 1'b1},
    {8'hFF, 8'h00, 2'd0, 1'b1, 1'b0},
    {8'h00, 8'hFF, 2'd1, 1'b0, 1'b1},
    {8'h6E, 8'hD9, 2'd2, 1'b1, 1'b1}
  };

  task automatic tick();
    @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0h expected %0h", tag, act, exp);
    end
  endtask

  task automatic hi(input logic d);
    bclk = 1'b1; rx_din = d; tick(); tick();
  endtask

  task automatic lo();
    bclk = 1'b0; tick(); tick();
  endtask

  task automatic idle(input int n);
    for (int i = 0; i < n; i++) begin hi(1'b0); lo(); end
  endtask

  task automatic run_frame(input logic [7:0] tx, input logic [7:0] rx,
                           input logic [1:0] mode, input logic dtx,
                           input logic drx, input logic ok);
    int v0;
    idle(2);
    tx_sample = tx;
    v0 = vcnt;
    if (mode == 2'd1) begin
      tx_sync = dtx; rx_sync = drx;
      tick();
      chk("R4 enable low while launch pending", tx_oe, 0);
      tick();
    end
    for (int i = 0; i < 8; i++) begin
      bclk = 1'b1; rx_din = rx[7-i];
      if (mode == 2'd0 && i == 0) begin tx_sync = dtx; rx_sync = drx; end
      tick();
      if (mode == 2'd2 && i == 0) begin tx_sync = dtx; rx_sync = drx; end
      if (i == 2) tx_sample = ~tx;
      tick();
      if (ok && dtx) begin
        chk("R1/R4 enable in slot", tx_oe, 1);
        chk("R1/R6 slot bit", tx_dout, tx[7-i]);
      end else begin
        chk("R11/R5 no slot without strobe", tx_oe, 0);
      end
      bclk = 1'b0;
      if (i == 1) begin tx_sync = 1'b0; rx_sync = 1'b0; end
      tick(); tick();
    end
    chk("R3 valid pulse count", vcnt, (ok && drx) ? v0 + 1 : v0);
    if (ok && drx) chk("R2 received byte", vlast, rx);
    bclk = 1'b1; tick(); tick();
    chk("R5 enable after slot", tx_oe, 0);
    chk("R5 released line reads high", tx_dout, 1);
    bclk = 1'b0; tick(); tick();
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: actual timeout expected finish");
    $display("%0d/%0d checks passed", checks + 1 - fails, checks + 1);
    $finish;
  end

  initial begin
    int v0;
    tick(); tick();
    rst_n = 1'b1;
    tick();
    chk("R10 reset rx_byte", rx_byte, 0);
    chk("R10 reset rx_valid", rx_valid, 0);
    chk("R10 reset tx_oe", tx_oe, 0);
    chk("R10 reset tx_dout", tx_dout, 1);

    for (int k = 0; k < 6; k++)
      run_frame(VEC[k][19:12], VEC[k][11:4], VEC[k][3:2], VEC[k][1], VEC[k][0], 1'b1);

    // R7: power-down in mid-frame
    idle(2);
    v0 = vcnt;
    tx_sample = 8'hC3;
    tx_sync = 1'b1; rx_sync = 1'b1;
    hi(1'b1);
    chk("R7 slot active before power-down", tx_oe, 1);
    lo();
    tx_sync = 1'b0; rx_sync = 1'b0;
    bclk = 1'b1; pd_n = 1'b0; tick(); tick();
    chk("R7 enable dropped in power-down", tx_oe, 0);
    bclk = 1'b0; tick(); tick();
    for (int i = 0; i < 6; i++) begin hi(1'b1); lo(); end
    pd_n = 1'b1;
    idle(2);
    chk("R7 aborted frame gives no valid", vcnt, v0);
    chk("R7 enable stays low", tx_oe, 0);
    run_frame(8'h5A, 8'hA5, 2'd0, 1'b1, 1'b1, 1'b1);

    // R8: bit clock stalls mid-frame
    idle(2);
    v0 = vcnt;
    tx_sync = 1'b1; rx_sync = 1'b1;
    hi(1'b0); lo();
    tx_sync = 1'b0; rx_sync = 1'b0;
    hi(1'b1);
    chk("R8 slot active before stall", tx_oe, 1);
    repeat (80) tick();
    chk("R8 stalled clock releases line", tx_oe, 0);
    lo();
    idle(8);
    chk("R8 partial frame discarded", vcnt, v0);
    chk("R8 no slot after stall", tx_oe, 0);

    // R9: transmit strobe starvation
    idle(330);
    run_frame(8'h00, 8'h96, 2'd0, 1'b0, 1'b1, 1'b0);
    run_frame(8'h3B, 8'h4D, 2'd1, 1'b1, 1'b1, 1'b1);

    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule